// File: doc/BRIEF.md
# 8-bit ALU with condition flags

This block is the arithmetic and logic unit of a small 8-bit accumulator machine. Each cycle it takes an operation code, the accumulator, a second operand and the current condition-code bits. It produces a result byte, a high byte that only multiply uses, and the next condition-code bits. The operations are pass-through load, inclusive OR, logical shift left and right, two's-complement negate, nibble swap of the accumulator, and an unsigned 8x8 multiply.

The result logic is combinational. One output register stage, cleared by an asynchronous active-low reset, follows it. Results therefore appear one clock after the inputs. The surrounding datapath chooses what to present on the operand port: memory, the index register low byte, or the accumulator itself for accumulator-form shifts. Each operation has its own rule for which flags it rewrites, clears or keeps.

The condition-code vector is 6 bits wide, ordered `{V,H,I,N,Z,C}` from bit 5 down to bit 0. The operation codes are PASS=0, OR=1, LSL=2, LSR=3, NEG=4, NSA=5, MUL=6 and HOLD=7.

Top module: `alu8_core`

## Requirements
- R1: While rst_ni is low, res_o, res_hi_o and ccr_o are all zero. Out of reset, every output reflects the inputs presented at the previous rising clock edge.
- R2: PASS (code 0) sets res = operand and clears V. N is set to result bit 7, and Z is set when the result is 0x00. H, I and C are kept. res_hi = 0.
- R3: OR (code 1) sets res = accumulator | operand and clears V. N and Z follow the result. H, I and C are kept. res_hi = 0.
- R4: LSL (code 2) shifts the operand left with a 0 into bit 0. C takes old bit 7. N and Z follow the result, and V = N xor C. H and I are kept.
- R5: LSR (code 3) shifts the operand right with a 0 into bit 7. C takes old bit 0. N is forced to 0, Z follows the result, and V = N xor C (so V = C). H and I are kept.
- R6: NEG (code 4) sets res = 0x00 - operand. C is set when the result is nonzero. V is set only when the operand is 0x80. N and Z follow the result. H and I are kept.
- R7: MUL (code 6) forms the 16-bit unsigned product of operand and accumulator. res_hi gets the high byte and res gets the low byte. H and C are cleared, and V, I, N and Z are kept.
- R8: NSA (code 5) sets res = accumulator with bits [3:0] and [7:4] exchanged. All six flags are kept. res_hi = 0.
- R9: HOLD (code 7) sets res = accumulator and res_hi = 0, and keeps all six flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| acc_i | input | DATA_W | Accumulator value |
| opd_i | input | DATA_W | Second operand (memory, index low, or accumulator) |
| ccr_i | input | 6 | Current flags {V,H,I,N,Z,C} |
| res_o | output | DATA_W | Result, low byte of product for MUL |
| res_hi_o | output | DATA_W | High byte of product for MUL, zero otherwise |
| ccr_o | output | 6 | Next flags {V,H,I,N,Z,C} |

## Verification
The bench builds the block with its default DATA_W of 8. At that width the sign boundary 0x80, the all-ones product 0xFF x 0xFF and the zero-result cases can be reached directly. Several hundred random operations with random incoming flags also cover a meaningful share of the operand space for every code. Randomising the incoming flags is what exposes a flag that is wrongly rewritten, since a flag that stays at 0 would hide a missing "keep" path.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_OR   = 3'd1,
    OP_LSL  = 3'd2,
    OP_LSR  = 3'd3,
    OP_NEG  = 3'd4,
    OP_NSA  = 3'd5,
    OP_MUL  = 3'd6,
    OP_HOLD = 3'd7
  } alu_op_e;

  localparam int CC_W = 6;
  localparam int CC_C = 0;
  localparam int CC_Z = 1;
  localparam int CC_N = 2;
  localparam int CC_I = 3;
  localparam int CC_H = 4;
  localparam int CC_V = 5;
endpackage

// File: rtl/alu8_shift.sv
`timescale 1ns/1ps
module alu8_shift #(
  parameter int DATA_W = 8,
  parameter bit LEFT   = 1'b1
) (
  input  logic [DATA_W-1:0] val_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);
  generate
    if (LEFT) begin : g_left
      assign res_o  = {val_i[DATA_W-2:0], 1'b0};
      assign cout_o = val_i[DATA_W-1];
    end else begin : g_right
      assign res_o  = {1'b0, val_i[DATA_W-1:1]};
      assign cout_o = val_i[0];
    end
  endgenerate
endmodule

// File: rtl/alu8_neg.sv
`timescale 1ns/1ps
module alu8_neg #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] val_i,
  output logic [DATA_W-1:0] res_o,
  output logic              ovf_o,
  output logic              borrow_o
);
  localparam logic [DATA_W-1:0] MinNeg = {1'b1, {(DATA_W-1){1'b0}}};

  assign res_o    = '0 - val_i;
  assign ovf_o    = (val_i == MinNeg);
  assign borrow_o = |val_i;
endmodule

// File: rtl/alu8_mul.sv
`timescale 1ns/1ps
module alu8_mul #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o
);
  localparam int ProdW = 2 * DATA_W;
  logic [ProdW-1:0] prod;

  assign prod = ProdW'(a_i) * ProdW'(b_i);
  assign lo_o = prod[DATA_W-1:0];
  assign hi_o = prod[ProdW-1:DATA_W];
endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opd_i,
  input  logic [CC_W-1:0]   ccr_i,
  output logic [DATA_W-1:0] res_o,
  output logic [DATA_W-1:0] res_hi_o,
  output logic [CC_W-1:0]   ccr_o
);
  localparam int HalfW = DATA_W / 2;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [DATA_W-1:0] lsl_res, lsr_res, neg_res, mul_lo, mul_hi;
  logic              lsl_c, lsr_c, neg_v, neg_c;

  alu8_shift #(.DATA_W(DATA_W), .LEFT(1'b1)) u_lsl (
    .val_i(opd_i), .res_o(lsl_res), .cout_o(lsl_c)
  );
  alu8_shift #(.DATA_W(DATA_W), .LEFT(1'b0)) u_lsr (
    .val_i(opd_i), .res_o(lsr_res), .cout_o(lsr_c)
  );
  alu8_neg #(.DATA_W(DATA_W)) u_neg (
    .val_i(opd_i), .res_o(neg_res), .ovf_o(neg_v), .borrow_o(neg_c)
  );
  alu8_mul #(.DATA_W(DATA_W)) u_mul (
    .a_i(opd_i), .b_i(acc_i), .lo_o(mul_lo), .hi_o(mul_hi)
  );

  logic [DATA_W-1:0] res_d, hi_d;
  logic [CC_W-1:0]   cc_d;
  logic              nz_upd, n_force0, v_nxc;

  always_comb begin
    res_d    = acc_i;
    hi_d     = '0;
    cc_d     = ccr_i;
    nz_upd   = 1'b0;
    n_force0 = 1'b0;
    v_nxc    = 1'b0;
    unique case (op)
      OP_PASS: begin
        res_d = opd_i; cc_d[CC_V] = 1'b0; nz_upd = 1'b1;
      end
      OP_OR: begin
        res_d = acc_i | opd_i; cc_d[CC_V] = 1'b0; nz_upd = 1'b1;
      end
      OP_LSL: begin
        res_d = lsl_res; cc_d[CC_C] = lsl_c; nz_upd = 1'b1; v_nxc = 1'b1;
      end
      OP_LSR: begin
        res_d = lsr_res; cc_d[CC_C] = lsr_c; nz_upd = 1'b1;
        n_force0 = 1'b1; v_nxc = 1'b1;
      end
      OP_NEG: begin
        res_d = neg_res; cc_d[CC_C] = neg_c; cc_d[CC_V] = neg_v; nz_upd = 1'b1;
      end
      OP_NSA: begin
        res_d = {acc_i[HalfW-1:0], acc_i[DATA_W-1:HalfW]};
      end
      OP_MUL: begin
        res_d = mul_lo; hi_d = mul_hi;
        cc_d[CC_H] = 1'b0; cc_d[CC_C] = 1'b0;
      end
      default: ;
    endcase
    if (nz_upd) begin
      cc_d[CC_N] = n_force0 ? 1'b0 : res_d[DATA_W-1];
      cc_d[CC_Z] = (res_d == '0);
    end
    // shifts: V from the freshly computed N and C
    if (v_nxc) cc_d[CC_V] = cc_d[CC_N] ^ cc_d[CC_C];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o    <= '0;
      res_hi_o <= '0;
      ccr_o    <= '0;
    end else begin
      res_o    <= res_d;
      res_hi_o <= hi_d;
      ccr_o    <= cc_d;
    end
  end
endmodule

// File: rtl/alu8_checker.sv
`timescale 1ns/1ps
module alu8_checker
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [DATA_W-1:0] opd_i,
  input logic [CC_W-1:0]   ccr_i,
  input logic [DATA_W-1:0] res_o,
  input logic [DATA_W-1:0] res_hi_o,
  input logic [CC_W-1:0]   ccr_o
);
  localparam logic [DATA_W-1:0] MinNeg = {1'b1, {(DATA_W-1){1'b0}}};

  logic primed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_zero: assert (res_o == '0 && res_hi_o == '0 && ccr_o == '0);
    end
  end

  a_r2_pass_clears_v: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(op_i) == OP_PASS |->
      res_o == $past(opd_i) && !ccr_o[CC_V] && ccr_o[CC_C] == $past(ccr_i[CC_C]));

  a_r4_lsl_v_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(op_i) == OP_LSL |->
      ccr_o[CC_C] == $past(opd_i[DATA_W-1]) && ccr_o[CC_V] == (ccr_o[CC_N] ^ ccr_o[CC_C]));

  a_r5_lsr_n_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(op_i) == OP_LSR |->
      !ccr_o[CC_N] && !res_o[DATA_W-1] && ccr_o[CC_V] == ccr_o[CC_C]);

  a_r6_neg_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(op_i) == OP_NEG |->
      ccr_o[CC_V] == ($past(opd_i) == MinNeg) && ccr_o[CC_C] == (res_o != '0));

  a_r7_mul_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(op_i) == OP_MUL |->
      !ccr_o[CC_H] && !ccr_o[CC_C] && ccr_o[CC_Z] == $past(ccr_i[CC_Z]));

  a_r8_nsa_flags_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(op_i) == OP_NSA |-> ccr_o == $past(ccr_i) && res_hi_o == '0);

  a_r9_hold_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(op_i) == OP_HOLD |-> ccr_o == $past(ccr_i) && res_o == $past(acc_i));
endmodule

bind alu8_core alu8_checker #(.DATA_W(DATA_W)) u_alu8_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .acc_i(acc_i), .opd_i(opd_i),
  .ccr_i(ccr_i), .res_o(res_o), .res_hi_o(res_hi_o), .ccr_o(ccr_o)
);

// File: tb/alu8_core_bench.sv
`timescale 1ns/1ps
module alu8_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] acc = '0, opd = '0;
  logic [5:0] ccr = '0;
  logic [7:0] res, res_hi;
  logic [5:0] ccr_q;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu8_core #(.DATA_W(8)) u_alu8_core (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .acc_i(acc), .opd_i(opd),
    .ccr_i(ccr), .res_o(res), .res_hi_o(res_hi), .ccr_o(ccr_q)
  );

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R8";
      3'd6: return "R7";
      default: return "R9";
    endcase
  endfunction

  // flags {V,H,I,N,Z,C}
  task automatic model(input logic [2:0] o, input logic [7:0] a, input logic [7:0] m,
                       input logic [5:0] f, output logic [7:0] r, output logic [7:0] h,
                       output logic [5:0] nf);
    int p;
    bit v = f[5], hh = f[4], i = f[3], n = f[2], z = f[1], c = f[0];
    h = 8'h00;
    r = a;
    case (o)
      3'd0: begin r = m; v = 0; n = r[7]; z = (r == 0); end
      3'd1: begin r = a | m; v = 0; n = r[7]; z = (r == 0); end
      3'd2: begin r = 8'((int'(m) * 2) % 256); c = (m >= 128); n = r[7]; z = (r == 0); v = n ^ c; end
      3'd3: begin r = 8'(int'(m) / 2); c = m[0]; n = 0; z = (r == 0); v = c; end
      3'd4: begin r = 8'((256 - int'(m)) % 256); c = (m != 0); v = (m == 8'h80); n = r[7]; z = (r == 0); end
      3'd5: begin r = {a[3:0], a[7:4]}; end
      3'd6: begin p = int'(a) * int'(m); r = 8'(p % 256); h = 8'(p / 256); hh = 0; c = 0; end
      default: ;
    endcase
    nf = {v, hh, i, n, z, c};
  endtask

  task automatic check(input string tag, input logic [7:0] er, input logic [7:0] eh,
                       input logic [5:0] ef);
    n_run++;
    if (res !== er || res_hi !== eh || ccr_q !== ef) begin
      n_fail++;
      $display("FAIL %s: got res=%02h hi=%02h ccr=%06b, expected res=%02h hi=%02h ccr=%06b",
               tag, res, res_hi, ccr_q, er, eh, ef);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [7:0] a, input logic [7:0] m,
                       input logic [5:0] f);
    logic [7:0] er, eh;
    logic [5:0] ef;
    @(negedge clk);
    op = o; acc = a; opd = m; ccr = f;
    model(o, a, m, f, er, eh, ef);
    @(negedge clk); // one register stage (R1)
    check(tag_of(o), er, eh, ef);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    op = 3'd6; acc = 8'hFF; opd = 8'hFF; ccr = 6'h3F;
    repeat (3) @(negedge clk);
    check("R1", 8'h00, 8'h00, 6'h00); // reset holds outputs at zero
    rst_n = 1'b1;

    apply(3'd0, 8'h00, 8'h80, 6'b111001);  // R2 negative load, C kept
    apply(3'd0, 8'h55, 8'h00, 6'b100000);  // R2 zero
    apply(3'd1, 8'h00, 8'h00, 6'b111111);  // R3 zero OR
    apply(3'd1, 8'hA0, 8'h05, 6'b000000);  // R3
    apply(3'd2, 8'h00, 8'h80, 6'b000000);  // R4 carry out, zero result
    apply(3'd2, 8'h00, 8'h40, 6'b011001);  // R4 into sign
    apply(3'd2, 8'h00, 8'hC0, 6'b000000);  // R4 N and C both set, V=0
    apply(3'd3, 8'h00, 8'h01, 6'b000100);  // R5 zero result with carry
    apply(3'd3, 8'h00, 8'hFE, 6'b111111);  // R5 N forced low
    apply(3'd4, 8'h00, 8'h80, 6'b000000);  // R6 overflow case
    apply(3'd4, 8'h00, 8'h00, 6'b111111);  // R6 zero operand
    apply(3'd4, 8'h00, 8'h01, 6'b000000);  // R6
    apply(3'd6, 8'hFF, 8'hFF, 6'b111111);  // R7 max product
    apply(3'd6, 8'h00, 8'h37, 6'b101110);  // R7 zero product keeps Z
    apply(3'd5, 8'h3C, 8'h00, 6'b101010);  // R8
    apply(3'd5, 8'hA5, 8'hFF, 6'b010101);  // R8
    apply(3'd7, 8'h9A, 8'h11, 6'b110011);  // R9

    for (int k = 0; k < 600; k++) begin
      apply(3'($urandom), 8'($urandom), 8'($urandom), 6'($urandom));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule